// File: doc/BRIEF.md
# Programmable Detector Clock Sequencer

This block generates the clock waveforms for an array detector from a small stored program rather than from fixed counter logic. An execution engine walks instructions in a local program memory. It emits clock-pattern words, with repeat counts, nested loops and jumps, so one program can describe a full-frame readout or any sub-window scan. The words are pushed into a deep FIFO. An output stage drains that FIFO at a fixed, programmable rate, so the pattern reaches the pins with even spacing. When the FIFO is full, the engine simply waits.

The program memory holds four independent clocking schemes. Each scheme starts at its own entry address. A host picks one scheme before each integration and then pulses a start strobe. The program itself does not have to be reloaded to change schemes. A byte-oriented command port, fed by an external serial receiver, lets the host do four things: write program words, set entry addresses, choose the scheme and the output rate, and read a status byte. One bit of every pattern word drives a conversion-sync output that tells the digitiser when to sample.

Top module: `detclk_sequencer`

## Requirements
- R1: After reset, `det_clk`, `pat_strobe`, `conv_sync`, `seq_busy`, `underrun` and `tx_valid` are 0, and a status read returns 0x00.
- R2: Host frames are built as an opcode byte followed by argument bytes, and multi-byte values are little-endian:
    - 0x01 writes a program word: address byte, then 4 data bytes.
    - 0x02 sets an entry address: scheme byte, then address byte.
    - 0x03 selects a scheme: one byte.
    - 0x04 reads status: no argument bytes.
    - 0x05 sets the divider: 2 bytes.
    - Any other opcode is ignored.
- R3: Instruction opcode is bits [31:29]. For OUT (1), bits [7:0] are the pattern, bit [8] is the sync flag and bits [24:9] are a repeat value n. OUT emits n+1 identical words, and each word with the sync flag set makes `conv_sync` pulse together with its `pat_strobe`.
- R4: LOOP (2) with count n in bits [15:0] runs the body up to the matching ENDLOOP (3) n+1 times. Loops nest up to 4 deep. A fifth nested LOOP stops the run and sets the nesting-error status bit.
- R5: JMP (4) continues at the address in bits [5:0]. END (0) returns the engine to idle.
- R6: A start pulse latches the selected scheme (0..3), raises `seq_busy` in the next cycle and begins at that scheme's entry address. Changing the selection between runs needs no program reload.
- R7: A start pulse while `seq_busy` is high is ignored. The run in progress and its scheme are unaffected.
- R8: When the FIFO is full, the engine waits. No generated word is lost or duplicated.
- R9: The output stage takes at most one word per div+1 clock cycles and signals each new word on `det_clk` with a one-cycle `pat_strobe`. While the FIFO stays non-empty, consecutive strobes are exactly div+1 cycles apart.
- R10: `underrun` rises when an output slot finds the FIFO empty while a run is active and at least one word of that run has already been output. It stays high until a status read.
- R11: A program-word write that completes while `seq_busy` is high does not change memory and sets the write-reject status bit.
- R12: The status byte is laid out as follows, and reading it clears bits 1 to 3:
    - bit 0: busy
    - bit 1: underrun
    - bit 2: write reject
    - bit 3: nesting error
    - bits [5:4]: scheme of the last accepted start

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Command byte present |
| rx_data | input | 8 | Command byte |
| tx_valid | output | 1 | Status byte present (one cycle) |
| tx_data | output | 8 | Status byte |
| integ_start | input | 1 | Start-of-integration strobe |
| det_clk | output | PAT_W | Detector clock pattern |
| pat_strobe | output | 1 | New pattern word on `det_clk` |
| conv_sync | output | 1 | Conversion sync pulse |
| seq_busy | output | 1 | Engine running a scheme |
| underrun | output | 1 | Sticky output underrun |

## Verification
The hardest situations to reach are the ones where the host acts while a run is in progress: a second start pulse, or a program write aimed at the first word of another scheme. These can only be reached while a run is in progress, and a run normally ends within a few cycles. The bench therefore starts a 40-word scheme with a slow divider. The 16-entry FIFO then fills and holds the engine stalled, and `seq_busy` stays high for about a hundred cycles. That window is used to send the stray start and the rejected write. Afterwards the bench counts the delivered words and reruns the other scheme to see that its first word is unchanged. Underrun is provoked by running a loop body that produces one word every other cycle while the divider is zero.

// File: rtl/detclk_pkg.sv
// Shared encodings for the detector clock sequencer: instruction opcodes
// and host command opcodes. Assumes 32-bit instruction words.
package detclk_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_LSB  = 29;
    localparam int CNT_W   = 16;

    typedef enum logic [2:0] {
        OP_END     = 3'd0,
        OP_OUT     = 3'd1,
        OP_LOOP    = 3'd2,
        OP_ENDLOOP = 3'd3,
        OP_JMP     = 3'd4
    } seq_op_e;

    localparam logic [7:0] CMD_WR_PROG  = 8'h01;
    localparam logic [7:0] CMD_WR_ENTRY = 8'h02;
    localparam logic [7:0] CMD_SEL      = 8'h03;
    localparam logic [7:0] CMD_STATUS   = 8'h04;
    localparam logic [7:0] CMD_DIV      = 8'h05;
endpackage

// File: rtl/seq_hostif.sv
// Host command decoder. Parses byte frames (opcode, then little-endian
// arguments), holds the entry table, scheme select and divider, and returns
// the status byte. Assumes ADDR_W <= 8 and DIV_W <= 16.
module seq_hostif
    import detclk_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    input  logic                   gen_busy,
    input  logic                   underrun,
    input  logic                   nest_err,
    input  logic [1:0]             act_sel,
    output logic                   prog_we,
    output logic [ADDR_W-1:0]      prog_addr,
    output logic [INSTR_W-1:0]     prog_wdata,
    output logic [3:0][ADDR_W-1:0] entry_tbl,
    output logic [1:0]             sel,
    output logic [DIV_W-1:0]       div_val,
    output logic                   clr_sticky
);
    logic [2:0]  left;
    logic [7:0]  cmd;
    logic [39:0] shreg;
    logic [39:0] nbuf;
    logic        wr_rej;
    logic [7:0]  status_b;
    logic        last_byte;
    logic        unused_nbuf;

    // Argument bytes shift in from the top; the final byte lands in bits 39:32.
    assign nbuf        = {rx_data, shreg[39:8]};
    assign last_byte   = rx_valid && (left == 3'd1);
    assign status_b    = {2'b00, act_sel, nest_err, wr_rej, underrun, gen_busy};
    assign prog_we     = last_byte && (cmd == CMD_WR_PROG) && !gen_busy;
    assign prog_addr   = nbuf[ADDR_W-1:0];
    assign prog_wdata  = nbuf[39:8];
    assign unused_nbuf = ^nbuf;

    // Frame parser and host register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left       <= 3'd0;
            cmd        <= 8'd0;
            shreg      <= '0;
            tx_valid   <= 1'b0;
            tx_data    <= 8'd0;
            clr_sticky <= 1'b0;
            wr_rej     <= 1'b0;
            entry_tbl  <= '0;
            sel        <= 2'd0;
            div_val    <= '0;
        end else begin
            tx_valid   <= 1'b0;
            clr_sticky <= 1'b0;
            if (rx_valid) begin
                if (left == 3'd0) begin
                    cmd <= rx_data;
                    case (rx_data)
                        CMD_WR_PROG:  left <= 3'd5;
                        CMD_WR_ENTRY: left <= 3'd2;
                        CMD_SEL:      left <= 3'd1;
                        CMD_DIV:      left <= 3'd2;
                        CMD_STATUS: begin
                            tx_valid   <= 1'b1;
                            tx_data    <= status_b;
                            clr_sticky <= 1'b1;
                            wr_rej     <= 1'b0;
                        end
                        default:      left <= 3'd0;
                    endcase
                end else begin
                    shreg <= nbuf;
                    left  <= left - 3'd1;
                    if (left == 3'd1) begin
                        case (cmd)
                            CMD_WR_PROG:  if (gen_busy) wr_rej <= 1'b1;
                            CMD_WR_ENTRY: entry_tbl[nbuf[25:24]] <= nbuf[32 +: ADDR_W];
                            CMD_SEL:      sel <= nbuf[33:32];
                            CMD_DIV:      div_val <= nbuf[24 +: DIV_W];
                            default:      ;
                        endcase
                    end
                end
            end
        end
    end

    // A new write reject can only come from a write during a run.
    p_reject_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_rej) |-> $past(gen_busy));
endmodule

// File: rtl/seq_engine.sv
// Micro-program execution engine. Fetches from program memory
// (combinational read), runs OUT/LOOP/ENDLOOP/JMP/END and pushes pattern
// words into the FIFO, stalling while it is full. Assumes NEST is a power of two.
module seq_engine
    import detclk_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PAT_W  = 8,
    parameter int NEST   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             sel,
    input  logic [3:0][ADDR_W-1:0] entry_tbl,
    output logic [ADDR_W-1:0]      pc,
    input  logic [INSTR_W-1:0]     instr,
    input  logic                   fifo_full,
    output logic                   push,
    output logic [PAT_W:0]         push_data,
    input  logic                   clr_sticky,
    output logic                   busy,
    output logic                   nest_err,
    output logic [1:0]             act_sel
);
    localparam int SP_W  = $clog2(NEST + 1);
    localparam int IDX_W = $clog2(NEST);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(NEST);
    localparam int REP_LSB = PAT_W + 1;

    seq_op_e          op;
    logic [CNT_W-1:0] rep_f;
    logic [CNT_W-1:0] loop_f;
    logic [CNT_W-1:0] rep_cnt;
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_dec;
    logic [IDX_W-1:0] top;
    logic [ADDR_W-1:0] stk_addr [NEST];
    logic [CNT_W-1:0]  stk_cnt  [NEST];
    logic             unused_eng;

    // Instruction field decode.
    assign op         = seq_op_e'(instr[INSTR_W-1:OP_LSB]);
    assign rep_f      = instr[REP_LSB +: CNT_W];
    assign loop_f     = instr[CNT_W-1:0];
    assign sp_dec     = sp - 1'b1;
    assign top        = sp_dec[IDX_W-1:0];
    assign push       = busy && (op == OP_OUT) && !fifo_full;
    assign push_data  = instr[PAT_W:0];
    assign unused_eng = ^{instr[OP_LSB-1:REP_LSB+CNT_W], sp_dec[SP_W-1]};

    // Sequencing state: start, program counter, repeat counter, loop stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pc       <= '0;
            rep_cnt  <= '0;
            sp       <= '0;
            nest_err <= 1'b0;
            act_sel  <= 2'd0;
        end else begin
            if (clr_sticky) nest_err <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    act_sel <= sel;
                    pc      <= entry_tbl[sel];
                    rep_cnt <= '0;
                    sp      <= '0;
                end
            end else begin
                case (op)
                    OP_OUT: if (!fifo_full) begin
                        if (rep_cnt == rep_f) begin
                            rep_cnt <= '0;
                            pc      <= pc + 1'b1;
                        end else begin
                            rep_cnt <= rep_cnt + 1'b1;
                        end
                    end
                    OP_LOOP: if (sp == SP_FULL) begin
                        nest_err <= 1'b1;
                        busy     <= 1'b0;
                    end else begin
                        stk_addr[sp[IDX_W-1:0]] <= pc + 1'b1;
                        stk_cnt[sp[IDX_W-1:0]]  <= loop_f;
                        sp <= sp + 1'b1;
                        pc <= pc + 1'b1;
                    end
                    OP_ENDLOOP: if (sp == '0) begin
                        pc <= pc + 1'b1;
                    end else if (stk_cnt[top] == '0) begin
                        sp <= sp_dec;
                        pc <= pc + 1'b1;
                    end else begin
                        stk_cnt[top] <= stk_cnt[top] - 1'b1;
                        pc <= stk_addr[top];
                    end
                    OP_JMP:  pc <= instr[ADDR_W-1:0];
                    default: busy <= 1'b0;
                endcase
            end
        end
    end

    // The running scheme never changes mid-run.
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(act_sel));
    // Stack depth stays within the nesting limit.
    p_nest_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_FULL);
endmodule

// File: rtl/seq_fifo.sv
// Pattern FIFO between engine and output stage. First-word-fall-through
// read; DEPTH must be a power of two. Writers must respect full.
module seq_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;

    assign rd_data = mem[rd_ptr[AW-1:0]];
    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // The engine must stall on full.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    // The output stage never pops an empty FIFO.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
endmodule

// File: rtl/seq_emitter.sv
// Output stage. A free-running divider gives one slot every div+1 cycles;
// each slot pops a word if available and drives it with a strobe, or
// flags an underrun when a started run has run dry.
module seq_emitter #(
    parameter int PAT_W = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             fifo_empty,
    input  logic [PAT_W:0]   fifo_head,
    output logic             pop,
    input  logic             gen_busy,
    input  logic             restart,
    input  logic             clr_sticky,
    output logic [PAT_W-1:0] det_clk,
    output logic             conv_sync,
    output logic             pat_strobe,
    output logic             underrun
);
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic             armed;

    assign tick = (div_cnt >= div_val);
    assign pop  = tick && !fifo_empty;

    // Rate divider.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end

    // Output registers, arming and sticky underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_clk    <= '0;
            conv_sync  <= 1'b0;
            pat_strobe <= 1'b0;
            armed      <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            pat_strobe <= pop;
            conv_sync  <= pop && fifo_head[PAT_W];
            if (pop) det_clk <= fifo_head[PAT_W-1:0];
            if (restart)  armed <= 1'b0;
            else if (pop) armed <= 1'b1;
            if (tick && fifo_empty && gen_busy && armed) underrun <= 1'b1;
            else if (clr_sticky)                         underrun <= 1'b0;
        end
    end

    // Underrun holds until a status read clears it.
    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !clr_sticky |=> underrun);
    // Sync is only ever given together with a new word.
    p_sync_with_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_sync |-> pat_strobe);
endmodule

// File: rtl/detclk_sequencer.sv
// Top of the detector clock sequencer: host command port, program memory,
// execution engine, pattern FIFO and rate-controlled output stage.
// Assumes a single clock and synchronous active-low reset.
module detclk_sequencer
    import detclk_pkg::*;
#(
    parameter int PAT_W      = 8,
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 16,
    parameter int NEST       = 4,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             integ_start,
    output logic [PAT_W-1:0] det_clk,
    output logic             pat_strobe,
    output logic             conv_sync,
    output logic             seq_busy,
    output logic             underrun
);
    localparam int PROG_DEPTH = 1 << ADDR_W;
    localparam int WORD_W     = PAT_W + 1;

    logic                   prog_we;
    logic [ADDR_W-1:0]      prog_addr;
    logic [INSTR_W-1:0]     prog_wdata;
    logic [3:0][ADDR_W-1:0] entry_tbl;
    logic [1:0]             sel;
    logic [DIV_W-1:0]       div_val;
    logic                   clr_sticky;
    logic                   nest_err;
    logic [1:0]             act_sel;
    logic [ADDR_W-1:0]      pc;
    logic [INSTR_W-1:0]     instr;
    logic                   push;
    logic [WORD_W-1:0]      push_data;
    logic                   pop;
    logic [WORD_W-1:0]      fifo_head;
    logic                   fifo_full;
    logic                   fifo_empty;
    logic                   restart;
    logic [INSTR_W-1:0]     prog_mem [PROG_DEPTH];

    assign restart = integ_start && !seq_busy;
    assign instr   = prog_mem[pc];

    // Program memory write port.
    always_ff @(posedge clk) begin
        if (prog_we) prog_mem[prog_addr] <= prog_wdata;
    end

    seq_hostif #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_hostif (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .gen_busy(seq_busy),
        .underrun(underrun), .nest_err(nest_err), .act_sel(act_sel),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .entry_tbl(entry_tbl), .sel(sel), .div_val(div_val),
        .clr_sticky(clr_sticky)
    );

    seq_engine #(.ADDR_W(ADDR_W), .PAT_W(PAT_W), .NEST(NEST)) i_engine (
        .clk(clk), .rst_n(rst_n), .start(integ_start), .sel(sel),
        .entry_tbl(entry_tbl), .pc(pc), .instr(instr), .fifo_full(fifo_full),
        .push(push), .push_data(push_data), .clr_sticky(clr_sticky),
        .busy(seq_busy), .nest_err(nest_err), .act_sel(act_sel)
    );

    seq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_data),
        .rd_en(pop), .rd_data(fifo_head), .full(fifo_full), .empty(fifo_empty)
    );

    seq_emitter #(.PAT_W(PAT_W), .DIV_W(DIV_W)) i_emitter (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .fifo_empty(fifo_empty),
        .fifo_head(fifo_head), .pop(pop), .gen_busy(seq_busy),
        .restart(restart), .clr_sticky(clr_sticky), .det_clk(det_clk),
        .conv_sync(conv_sync), .pat_strobe(pat_strobe), .underrun(underrun)
    );

    // An accepted start runs the scheme selected at that moment.
    p_start_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        integ_start && !seq_busy |=> seq_busy && (act_sel == $past(sel)));
endmodule

// File: tb/test_detclk_sequencer.sv
module test_detclk_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       integ_start = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic [7:0] det_clk;
    logic       pat_strobe, conv_sync, seq_busy, underrun;

    int n_chk = 0;
    int n_err = 0;

    // Output monitor state.
    int cyc = 0, wcnt = 0, syncs = 0, last_cyc = 0, mingap = 0, maxgap = 0;
    logic [7:0] first_w, last_w;
    logic [7:0] rec [64];
    bit saw_ee = 0;

    always #5 clk = ~clk;

    detclk_sequencer i_detclk_sequencer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .integ_start(integ_start),
        .det_clk(det_clk), .pat_strobe(pat_strobe), .conv_sync(conv_sync),
        .seq_busy(seq_busy), .underrun(underrun)
    );

    // Stimulus/expectation table: sel, div, words, first, last, syncs.
    localparam logic [41:0] TBL [3] = '{
        {2'd0, 8'd3, 8'd8,  8'hA5, 8'h00, 8'd1},
        {2'd1, 8'd3, 8'd40, 8'h0F, 8'h0F, 8'd0},
        {2'd0, 8'd7, 8'd8,  8'hA5, 8'h00, 8'd1}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (pat_strobe) begin
                if (wcnt == 0) first_w = det_clk;
                else begin
                    if (mingap == 0 || cyc - last_cyc < mingap) mingap = cyc - last_cyc;
                    if (cyc - last_cyc > maxgap) maxgap = cyc - last_cyc;
                end
                if (wcnt < 64) rec[wcnt] = det_clk;
                if (det_clk == 8'hEE) saw_ee = 1;
                if (conv_sync) syncs = syncs + 1;
                last_w   = det_clk;
                last_cyc = cyc;
                wcnt     = wcnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        wcnt = 0; syncs = 0; mingap = 0; maxgap = 0; saw_ee = 0;
        first_w = 8'hxx; last_w = 8'hxx;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic wr_prog(input logic [7:0] a, input logic [31:0] w);
        send_byte(8'h01); send_byte(a);
        send_byte(w[7:0]); send_byte(w[15:8]); send_byte(w[23:16]); send_byte(w[31:24]);
    endtask

    task automatic wr_entry(input logic [7:0] s, input logic [7:0] a);
        send_byte(8'h02); send_byte(s); send_byte(a);
    endtask

    task automatic sel_scheme(input logic [7:0] s);
        send_byte(8'h03); send_byte(s);
    endtask

    task automatic set_div(input logic [15:0] d);
        send_byte(8'h05); send_byte(d[7:0]); send_byte(d[15:8]);
    endtask

    task automatic read_status(output logic v, output logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h04;
        @(negedge clk); rx_valid = 1'b0; v = tx_valid; d = tx_data;
    endtask

    task automatic start_pulse();
        @(negedge clk); integ_start = 1'b1;
        @(negedge clk); integ_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && seq_busy; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] i_out(logic [7:0] p, logic s, logic [15:0] r);
        return {3'd1, 4'd0, r, s, p};
    endfunction
    function automatic logic [31:0] i_loop(logic [15:0] c);
        return {3'd2, 13'd0, c};
    endfunction
    function automatic logic [31:0] i_jmp(logic [5:0] a);
        return {3'd4, 23'd0, a};
    endfunction
    localparam logic [31:0] I_ENDL = {3'd3, 29'd0};
    localparam logic [31:0] I_END  = 32'd0;

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic       v;
        logic [7:0] st;
        logic [7:0] exp_seq [8];
        exp_seq = '{8'hA5, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h00};
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "det_clk", det_clk, 0);
        check("R1", "pat_strobe", pat_strobe, 0);
        check("R1", "seq_busy", seq_busy, 0);
        check("R1", "underrun", underrun, 0);
        check("R1", "tx_valid", tx_valid, 0);
        read_status(v, st);
        check("R1", "status valid", v, 1);
        check("R1", "status", st, 8'h00);

        // Load the four schemes (R2 framing); an unknown opcode is ignored.
        send_byte(8'h7E);
        wr_prog(0, i_out(8'hA5, 1'b1, 16'd0));
        wr_prog(1, i_loop(16'd2));
        wr_prog(2, i_out(8'h3C, 1'b0, 16'd1));
        wr_prog(3, I_ENDL);
        wr_prog(4, i_out(8'h00, 1'b0, 16'd0));
        wr_prog(5, I_END);
        wr_prog(10, i_jmp(6'd12));
        wr_prog(11, i_out(8'hEE, 1'b0, 16'd0));
        wr_prog(12, i_out(8'h0F, 1'b0, 16'd39));
        wr_prog(13, I_END);
        wr_prog(20, i_loop(16'd3));
        wr_prog(21, i_out(8'h11, 1'b0, 16'd0));
        wr_prog(22, I_ENDL);
        wr_prog(23, I_END);
        for (int k = 30; k < 35; k++) wr_prog(8'(k), i_loop(16'd0));
        wr_prog(35, I_END);
        wr_entry(0, 0); wr_entry(1, 10); wr_entry(2, 20); wr_entry(3, 30);

        // Table-driven runs: R3 R4 R5 R6 R8 R9 R12
        for (int r = 0; r < 3; r++) begin
            logic [41:0] t;
            t = TBL[r];
            clear_mon();
            sel_scheme({6'd0, t[41:40]});
            set_div({8'd0, t[39:32]});
            start_pulse();
            check("R6", "busy after start", seq_busy, 1);
            wait_idle();
            repeat (300) @(negedge clk);
            check("R8", "word count", wcnt, t[31:24]);
            check("R3", "first word", first_w, t[23:16]);
            check("R3", "last word", last_w, t[15:8]);
            check("R3", "sync pulses", syncs, t[7:0]);
            check("R9", "min gap", mingap, t[39:32] + 1);
            check("R9", "max gap", maxgap, t[39:32] + 1);
            check("R5", "skipped word absent", saw_ee, 0);
            check("R10", "no underrun", underrun, 0);
            read_status(v, st);
            check("R12", "status after run", st, {2'b00, t[41:40], 4'b0000});
            if (r == 0)
                for (int k = 0; k < 8; k++) check("R4", "loop sequence", rec[k], exp_seq[k]);
        end

        // R7/R11: stray start and rejected write during a long run.
        clear_mon();
        sel_scheme(1);
        set_div(3);
        start_pulse();
        repeat (5) @(negedge clk);
        sel_scheme(0);
        start_pulse();
        wr_prog(0, i_out(8'hFF, 1'b0, 16'd0));
        check("R7", "still busy", seq_busy, 1);
        wait_idle();
        repeat (300) @(negedge clk);
        check("R7", "word count unaffected", wcnt, 40);
        check("R7", "pattern unaffected", last_w, 8'h0F);
        read_status(v, st);
        check("R11", "status reject", st, 8'h14);
        read_status(v, st);
        check("R12", "reject cleared", st, 8'h10);
        clear_mon();
        start_pulse();
        wait_idle();
        repeat (300) @(negedge clk);
        check("R11", "memory kept", first_w, 8'hA5);
        check("R6", "reselect without reload", wcnt, 8);

        // R10: underrun with a slow producer and divider 0.
        clear_mon();
        sel_scheme(2);
        set_div(0);
        start_pulse();
        wait_idle();
        repeat (20) @(negedge clk);
        check("R10", "underrun set", underrun, 1);
        check("R4", "loop words", wcnt, 4);
        read_status(v, st);
        check("R12", "status underrun", st, 8'h22);
        @(negedge clk);
        check("R10", "underrun cleared", underrun, 0);

        // R4: fifth nested loop aborts the run.
        clear_mon();
        sel_scheme(3);
        start_pulse();
        repeat (30) @(negedge clk);
        check("R4", "busy after nest abort", seq_busy, 0);
        check("R4", "no words", wcnt, 0);
        read_status(v, st);
        check("R4", "nest error status", st, 8'h38);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule